// File: doc/BRIEF.md
# Streaming 3x3 Image Convolver

The block accepts a non-interlaced raster stream of 8-bit unsigned pixels, one per clock, and produces a 20-bit signed convolution of each pixel's 3x3 neighbourhood with one of two kernels held on chip. Two delay lines of programmable length supply the two previous image rows. A third output carries the incoming pixel stream delayed by two row lengths, so a second stage can work on it.

A host sets up the block through a small register port. It places an address and data on the port, pulls chip-select low, and pulses the load strobe low then high. Three registers are decoded. Address 0 is the coefficient port, address 1 is the initialization register, and address 2 is the row length. A frame-start input clears the datapath and keeps the configuration. A stall input freezes the pipeline, and it takes effect one clock after it is sampled.

Top module: `raster_conv3x3`

## Requirements
- R1: When `rst_n` is sampled low, both outputs read 0 after that edge. All configuration returns to zero: coefficients 0, kernel 0, coefficient pointer 0 and row length 0.
- R2: A configuration write happens at the clock edge where `cfg_ld_n` is sampled high and `cfg_cs_n` is sampled low, provided the previous edge sampled both `cfg_ld_n` and `cfg_cs_n` low. Address and data are taken at the writing edge. If `cfg_cs_n` is high at that edge, nothing is written.
- R3: A write to address 0 stores the signed value `cfg_data[7:0]` into slot `ptr` of an 18-slot coefficient store. The pointer then advances and wraps from 17 back to 0. A write to address 1 clears the pointer and selects the active kernel from `cfg_data[0]`: value 0 selects slots 0..8 and value 1 selects slots 9..17.
- R4: A write to address 2 sets the row length L from `cfg_data[9:0]`. A programmed value below 3 acts as 3.
- R5: Number the pixels accepted since the last frame start as p[0], p[1], and so on, where p[m] is taken at the m-th advancing edge. After the edge that takes p[m], `conv_out` equals y[m-2] in 20-bit two's complement. Here y[n] = sum over r,c in 0..2 of k[3r+c]*p[n-rL-c], and k[i] is the active kernel's slot i.
- R6: A pixel index below 0 (before the frame start) contributes 0 to R5 and R7, so the outputs fill with zeros until the delay lines have filled.
- R7: After the edge that takes p[m], `casc_out` equals p[m-1-2L].
- R8: `hold` is registered at every edge. While the registered value is 1, no pixel is taken and neither output changes. Release follows the same one-edge lag.
- R9: When `frame_n` is sampled low, both outputs read 0 after that edge and the pixel count restarts. This applies even while held. The coefficients, kernel selection and row length are kept.
- R10: For every pixel and coefficient value the result is exact. Nine products of 255 and -128 give -293760, and nine of 255 and 127 give 291465.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Synchronous active-low frame start |
| hold | input | 1 | Stall request, effective one edge after sampling |
| pix_in | input | 8 | Raster pixel input |
| cfg_cs_n | input | 1 | Configuration chip-select, active low |
| cfg_ld_n | input | 1 | Configuration load strobe, write on its rise |
| cfg_addr | input | 3 | Configuration register address |
| cfg_data | input | 10 | Configuration write data |
| conv_out | output | 20 | Signed convolution result |
| casc_out | output | 8 | Pixel stream delayed by two row lengths |

## Verification
The embedded properties assume that `rst_n` is driven low from time zero until the first few clocks. They also assume that every control input holds a known level at each edge, and that the host never changes the row length in the middle of a frame. The bench drives inputs only on falling edges and always starts with reset. It changes configuration only while `frame_n` is held low, then starts a new frame. Pixels and coefficients are drawn at random from a fixed seed, and the stall input is toggled at random. Directed cases cover extreme coefficients, clamped and maximal row lengths, and write attempts that must be ignored.

// File: rtl/rconv_pkg.sv
// Package: shared constants and types for the 3x3 raster convolver.
// Assumes a square 3x3 window and two kernels held on chip.
package rconv_pkg;
    localparam int ROWS    = 3;
    localparam int COLS    = 3;
    localparam int TAPS    = ROWS * COLS;
    localparam int KERNELS = 2;
    localparam int MIN_ROW = 3;

    typedef enum logic [2:0] {
        RA_COEF   = 3'd0,
        RA_INIT   = 3'd1,
        RA_ROWLEN = 3'd2
    } reg_addr_e;
endpackage

// File: rtl/rconv_cfg.sv
// Module: configuration register file loaded by a chip-select/strobe pair.
// The strobe is sampled on the pixel clock. A write fires on the edge
// where the strobe is seen high after an edge that saw it low with
// chip-select low. Chip-select must also be low at the writing edge.
// Assumes the strobe is held low for at least one clock.
module rconv_cfg
    import rconv_pkg::*;
#(
    parameter int CFG_W  = 10,
    parameter int ADDR_W = 3,
    parameter int ROW_W  = 10,
    parameter int COEF_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_i,
    input  logic                     ld_n_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CFG_W-1:0]         data_i,
    output logic signed [COEF_W-1:0] coef_o [TAPS],
    output logic [ROW_W-1:0]         row_len_o
);
    localparam int SLOTS  = TAPS * KERNELS;
    localparam int PTR_W  = $clog2(SLOTS);
    localparam int KSEL_W = (KERNELS > 1) ? $clog2(KERNELS) : 1;

    logic                     arm_q;
    logic                     wr;
    logic signed [COEF_W-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0]         ptr_q;
    logic [KSEL_W-1:0]        ksel_q;
    logic [ROW_W-1:0]         rowlen_q;
    logic [PTR_W-1:0]         base;

    assign wr = arm_q && !cs_n_i && ld_n_i;

    // Remember that the strobe was low while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= !cs_n_i && !ld_n_i;
    end

    // Decode a write into the coefficient store, pointer, kernel and row length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
            ptr_q    <= '0;
            ksel_q   <= '0;
            rowlen_q <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr_i))
                RA_COEF: begin
                    slot_q[ptr_q] <= data_i[COEF_W-1:0];
                    ptr_q <= (ptr_q == PTR_W'(SLOTS - 1)) ? '0 : ptr_q + 1'b1;
                end
                RA_INIT: begin
                    ptr_q  <= '0;
                    ksel_q <= data_i[KSEL_W-1:0];
                end
                RA_ROWLEN: rowlen_q <= data_i[ROW_W-1:0];
                default: ;
            endcase
        end
    end

    assign base = PTR_W'(ksel_q) * PTR_W'(TAPS);

    // Present the active kernel.
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign coef_o[g] = slot_q[base + PTR_W'(g)];
    end

    // Clamp short row lengths to the minimum the window needs.
    assign row_len_o = (rowlen_q < ROW_W'(MIN_ROW)) ? ROW_W'(MIN_ROW) : rowlen_q;

    p_cs_guard_r2: assert property (@(posedge clk)
        rst_n && cs_n_i |=> $stable(rowlen_q) && $stable(ksel_q) && $stable(ptr_q));

    p_init_ptr_r3: assert property (@(posedge clk)
        rst_n && wr && (addr_i == ADDR_W'(RA_INIT)) |=> (ptr_q == '0));

    p_ptr_range_r3: assert property (@(posedge clk)
        rst_n |-> (ptr_q < PTR_W'(SLOTS)));
endmodule

// File: rtl/rconv_linebuf.sv
// Module: one row delay line of programmable length.
// A circular store is read at the write pointer before it is written.
// A value therefore reappears after exactly len advancing edges.
// Assumes len stays constant within a frame and is at least 1.
module rconv_linebuf #(
    parameter int PIX_W = 8,
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [ROW_W-1:0] len_i,
    input  logic [PIX_W-1:0] din_i,
    output logic [PIX_W-1:0] dout_o
);
    localparam int DEPTH = 1 << ROW_W;

    logic [PIX_W-1:0] mem [DEPTH];
    logic [ROW_W-1:0] ptr_q;
    logic             wrap;

    assign wrap   = (ptr_q >= len_i - 1'b1);
    assign dout_o = mem[ptr_q];

    // Store the incoming sample at the pointer.
    always_ff @(posedge clk) begin
        if (rst_n && !clr_i && adv_i) mem[ptr_q] <= din_i;
    end

    // Step the pointer round the programmed length.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) ptr_q <= '0;
        else if (adv_i)      ptr_q <= wrap ? '0 : ptr_q + 1'b1;
    end

    p_wrap_r4: assert property (@(posedge clk)
        rst_n && !clr_i && adv_i && (ptr_q == len_i - 1'b1) |=> (ptr_q == '0));
endmodule

// File: rtl/rconv_mac.sv
// Module: 3x3 window registers, nine signed products and their sum.
// Row 0 is the current row and column 0 the newest pixel.
// Products are registered one edge and the sum the next.
// Assumes the row inputs are already zero-masked where invalid.
module rconv_mac
    import rconv_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    parameter int RES_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     adv_i,
    input  logic [PIX_W-1:0]         row_i [ROWS],
    input  logic signed [COEF_W-1:0] coef_i [TAPS],
    output logic [RES_W-1:0]         res_o
);
    localparam int PROD_W = PIX_W + COEF_W + 1;
    localparam int MAXV   = TAPS * ((1 << PIX_W) - 1) * (1 << (COEF_W - 1));

    logic [PIX_W-1:0]         dly_q [ROWS][COLS-1];
    logic [PIX_W-1:0]         win   [TAPS];
    logic signed [PROD_W-1:0] prod_q [TAPS];
    logic signed [RES_W-1:0]  sum_c;
    logic signed [RES_W-1:0]  sum_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign win[r*COLS] = row_i[r];
        for (genvar c = 1; c < COLS; c++) begin : g_col
            assign win[r*COLS + c] = dly_q[r][c-1];
        end
    end

    // Shift each row's pixels through the horizontal taps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS - 1; c++) dly_q[r][c] <= '0;
        end else if (adv_i) begin
            for (int r = 0; r < ROWS; r++) begin
                dly_q[r][0] <= row_i[r];
                for (int c = 1; c < COLS - 1; c++) dly_q[r][c] <= dly_q[r][c-1];
            end
        end
    end

    // Register the nine pixel-by-coefficient products.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int t = 0; t < TAPS; t++) prod_q[t] <= '0;
        end else if (adv_i) begin
            for (int t = 0; t < TAPS; t++)
                prod_q[t] <= PROD_W'($signed({1'b0, win[t]})) * PROD_W'(coef_i[t]);
        end
    end

    // Add the sign-extended products.
    always_comb begin
        sum_c = '0;
        for (int t = 0; t < TAPS; t++) sum_c = sum_c + RES_W'(prod_q[t]);
    end

    // Register the final result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) sum_q <= '0;
        else if (adv_i)      sum_q <= sum_c;
    end

    assign res_o = sum_q;

    p_sum_bound_r10: assert property (@(posedge clk)
        rst_n |-> (sum_q >= -MAXV) && (sum_q <= MAXV));

    p_clear_r9: assert property (@(posedge clk)
        rst_n && clr_i |=> (sum_q == '0));
endmodule

// File: rtl/raster_conv3x3.sv
// Module: top of the streaming 3x3 convolver.
// It registers the pixel, counts pixels since the frame start, chains two
// line delays and masks their outputs until they hold pixels of this
// frame. It feeds the window multiply-add and the cascade register.
// Assumes configuration is changed only between frames.
module raster_conv3x3
    import rconv_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    parameter int RES_W  = 20,
    parameter int CFG_W  = 10,
    parameter int ADDR_W = 3,
    parameter int ROW_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              hold,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              cfg_cs_n,
    input  logic              cfg_ld_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic [RES_W-1:0]  conv_out,
    output logic [PIX_W-1:0]  casc_out
);
    localparam int LINES = ROWS - 1;
    localparam int CNT_W = ROW_W + 2;

    logic                     hold_q;
    logic                     adv;
    logic                     clr;
    logic [PIX_W-1:0]         pix_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [PIX_W-1:0]         casc_q;
    logic [ROW_W-1:0]         row_len;
    logic signed [COEF_W-1:0] coef [TAPS];
    logic [PIX_W-1:0]         lb_in  [LINES];
    logic [PIX_W-1:0]         lb_out [LINES];
    logic [CNT_W-1:0]         thr    [LINES];
    logic [PIX_W-1:0]         rows   [ROWS];

    assign adv = !hold_q;
    assign clr = !frame_n;

    // Register the stall request so it acts one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold;
    end

    // Capture the pixel and count pixels since the frame start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pix_q <= '0;
            cnt_q <= '0;
        end else if (adv) begin
            pix_q <= pix_in;
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    rconv_cfg #(
        .CFG_W (CFG_W),
        .ADDR_W(ADDR_W),
        .ROW_W (ROW_W),
        .COEF_W(COEF_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cfg_cs_n),
        .ld_n_i   (cfg_ld_n),
        .addr_i   (cfg_addr),
        .data_i   (cfg_data),
        .coef_o   (coef),
        .row_len_o(row_len)
    );

    assign rows[0] = pix_q;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        if (g == 0) begin : g_first
            assign lb_in[g] = pix_q;
        end else begin : g_next
            assign lb_in[g] = lb_out[g-1];
        end

        rconv_linebuf #(
            .PIX_W(PIX_W),
            .ROW_W(ROW_W)
        ) u_lb (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr),
            .adv_i (adv),
            .len_i (row_len),
            .din_i (lb_in[g]),
            .dout_o(lb_out[g])
        );

        assign thr[g]    = CNT_W'(row_len) * CNT_W'(g + 1);
        assign rows[g+1] = (cnt_q > thr[g]) ? lb_out[g] : '0;
    end

    rconv_mac #(
        .PIX_W (PIX_W),
        .COEF_W(COEF_W),
        .RES_W (RES_W)
    ) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .adv_i (adv),
        .row_i (rows),
        .coef_i(coef),
        .res_o (conv_out)
    );

    // Register the oldest visible row as the cascade stream.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) casc_q <= '0;
        else if (adv)      casc_q <= rows[ROWS-1];
    end

    assign casc_out = casc_q;

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (conv_out == '0) && (casc_out == '0));

    p_hold_freeze_r8: assert property (@(posedge clk)
        rst_n && frame_n && hold_q |=> $stable(conv_out) && $stable(casc_out));

    p_frame_clear_r9: assert property (@(posedge clk)
        rst_n && !frame_n |=> (conv_out == '0) && (casc_out == '0));

    p_casc_fill_r6: assert property (@(posedge clk)
        rst_n && frame_n && !hold_q && (cnt_q <= thr[LINES-1]) |=> (casc_out == '0));
endmodule

// File: tb/raster_conv3x3_tb_top.sv
// Bench: random and directed stimulus against a behavioural model of the
// convolver requirements. Inputs are driven on falling edges and outputs
// are compared on the following falling edge.
module raster_conv3x3_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b0;
    logic       hold = 1'b0;
    logic [7:0] pix_in = '0;
    logic       cfg_cs_n = 1'b1;
    logic       cfg_ld_n = 1'b1;
    logic [2:0] cfg_addr = '0;
    logic [9:0] cfg_data = '0;
    logic [19:0] conv_out;
    logic [7:0]  casc_out;

    always #5 clk = ~clk;

    raster_conv3x3 dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .hold(hold),
        .pix_in(pix_in), .cfg_cs_n(cfg_cs_n), .cfg_ld_n(cfg_ld_n),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .conv_out(conv_out), .casc_out(casc_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string tag_conv = "R1";
    string tag_casc = "R1";

    // Model state
    int m_coef [18];
    int m_ptr, m_ksel, m_rowlen, m_npix;
    bit m_arm, m_hold_q;
    int hist [4096];
    int exp_conv, exp_casc;

    function automatic int eff_len();
        return (m_rowlen < 3) ? 3 : m_rowlen;
    endfunction

    function automatic int model_y(int m);
        int acc = 0;
        int len = eff_len();
        if (m < 0) return 0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                int idx = m - r * len - c;
                if (idx >= 0) acc += m_coef[m_ksel * 9 + r * 3 + c] * hist[idx];
            end
        return acc;
    endfunction

    task automatic model_edge();
        bit en = !m_hold_q;
        if (!rst_n) begin
            for (int i = 0; i < 18; i++) m_coef[i] = 0;
            m_ptr = 0; m_ksel = 0; m_rowlen = 0; m_npix = 0;
            m_arm = 0; m_hold_q = 0; exp_conv = 0; exp_casc = 0;
            return;
        end
        if (m_arm && !cfg_cs_n && cfg_ld_n) begin
            case (cfg_addr)
                3'd0: begin
                    m_coef[m_ptr] = int'($signed(cfg_data[7:0]));
                    m_ptr = (m_ptr == 17) ? 0 : m_ptr + 1;
                end
                3'd1: begin m_ptr = 0; m_ksel = int'(cfg_data[0]); end
                3'd2: m_rowlen = int'(cfg_data);
                default: ;
            endcase
        end
        m_arm = !cfg_cs_n && !cfg_ld_n;
        m_hold_q = hold;
        if (!frame_n) begin
            m_npix = 0; exp_conv = 0; exp_casc = 0;
        end else if (en) begin
            int n = m_npix;
            int ci;
            hist[n] = int'(pix_in);
            if (m_npix < 4095) m_npix++;
            exp_conv = model_y(n - 2);
            ci = n - 1 - 2 * eff_len();
            exp_casc = (ci >= 0) ? hist[ci] : 0;
        end
    endtask

    task automatic check(string tag, string what, int got, int expv);
        n_cmp++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, expv, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag_conv, "conv_out", int'($signed(conv_out)), exp_conv);
        check(tag_casc, "casc_out", int'(casc_out), exp_casc);
    endtask

    task automatic cfg_write(logic [2:0] a, logic [9:0] d);
        cfg_cs_n = 0; cfg_ld_n = 0; cfg_addr = a; cfg_data = d;
        tick();
        cfg_ld_n = 1;
        tick();
        cfg_cs_n = 1;
        tick();
    endtask

    task automatic load_kernel(int sel, int mode, int val);
        cfg_write(3'd1, 10'(sel));
        for (int i = 0; i < 9; i++) begin
            int c = (mode == 0) ? (int'($urandom % 256) - 128) : val;
            cfg_write(3'd0, {2'b00, 8'(c)});
        end
    endtask

    task automatic stream(int count, int hold_pct, int fixed);
        for (int i = 0; i < count; i++) begin
            pix_in = (fixed >= 0) ? 8'(fixed) : 8'($urandom);
            hold = (int'($urandom % 100) < hold_pct);
            tick();
        end
        hold = 0;
    endtask

    task automatic new_frame();
        frame_n = 0; tick(); tick(); frame_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        @(negedge clk);
        // R1: reset state
        tag_conv = "R1"; tag_casc = "R1";
        repeat (3) tick();
        rst_n = 1;
        frame_n = 1;
        // R1 zero coefficients; R4 default row length clamps to 3
        tag_conv = "R1"; tag_casc = "R4";
        stream(30, 0, -1);
        // R9: outputs clear while the frame input is low during set-up
        tag_conv = "R9"; tag_casc = "R9";
        frame_n = 0;
        load_kernel(0, 0, 0);
        for (int i = 0; i < 9; i++) cfg_write(3'd0, {2'b00, 8'($urandom)});
        cfg_write(3'd2, 10'd8);
        frame_n = 1;
        // R5, R7: kernel 0 over random pixels
        tag_conv = "R5"; tag_casc = "R7";
        stream(60, 0, -1);
        // R3: select the second kernel
        frame_n = 0; cfg_write(3'd1, 10'd1); frame_n = 1;
        tag_conv = "R3"; tag_casc = "R7";
        stream(50, 0, -1);
        // R2: writes without chip-select, or with it dropped before the strobe rise
        frame_n = 0;
        cfg_cs_n = 1; cfg_ld_n = 0; cfg_addr = 3'd2; cfg_data = 10'd5; tick();
        cfg_ld_n = 1; tick();
        cfg_cs_n = 0; cfg_ld_n = 0; cfg_addr = 3'd1; cfg_data = 10'd0; tick();
        cfg_cs_n = 1; cfg_ld_n = 1; tick(); tick();
        frame_n = 1;
        tag_conv = "R2"; tag_casc = "R2";
        stream(40, 0, -1);
        // R3: pointer restarts at slot 0, partial reload of kernel 0
        frame_n = 0;
        cfg_write(3'd1, 10'd0);
        for (int i = 0; i < 3; i++) cfg_write(3'd0, {2'b00, 8'($urandom)});
        frame_n = 1;
        tag_conv = "R3"; tag_casc = "R7";
        stream(40, 0, -1);
        // R10: extreme negative then positive coefficients with full-scale pixels
        frame_n = 0; load_kernel(0, 1, -128); cfg_write(3'd2, 10'd4); frame_n = 1;
        tag_conv = "R10"; tag_casc = "R7";
        stream(30, 0, 255);
        frame_n = 0; load_kernel(0, 1, 127); frame_n = 1;
        stream(30, 0, 255);
        // R8: random stalls
        frame_n = 0; load_kernel(1, 0, 0); cfg_write(3'd2, 10'd6); frame_n = 1;
        tag_conv = "R8"; tag_casc = "R8";
        stream(120, 30, -1);
        // R9 then R6: restart mid-stream, configuration kept, zero fill again
        tag_conv = "R9"; tag_casc = "R9";
        stream(20, 0, -1);
        hold = 1; new_frame(); hold = 0;
        tag_conv = "R6"; tag_casc = "R6";
        stream(40, 0, -1);
        // R4: row length below minimum, then a long row
        frame_n = 0; cfg_write(3'd2, 10'd1); frame_n = 1;
        tag_conv = "R4"; tag_casc = "R4";
        stream(30, 0, -1);
        frame_n = 0; cfg_write(3'd2, 10'd20); frame_n = 1;
        stream(70, 10, -1);
        // R7: maximal row length
        frame_n = 0; cfg_write(3'd2, 10'd1023); frame_n = 1;
        tag_conv = "R5"; tag_casc = "R7";
        stream(2100, 0, -1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule